// File: doc/BRIEF.md
# Deep Sleep Power Sequencer

This block sequences a processor subsystem into and out of a deep sleep state in which part of the die loses power. Software arms the sleep through a control bit. While the block is armed and idle, a wake-up event starts a programmable delay. Once the delay ends, the block raises an enable that tells an external regulator to switch power back on.

The enable stays high until the regulator reports power good or a programmable ramp timeout ends, whichever comes first. It also stays high for a minimum number of cycles, so that a receiver in another clock domain can sample it. After the enable drops, the core is kept in reset for a programmable number of cycles so that its clock generator can settle. When the core leaves reset after a wake-up, a sticky status flag records that this was a warm boot and not a cold power-on.

All timing values sit in 16-bit registers behind a simple write/read port. The power-good input passes through a synchronizer before use.

Top module: `dslp_seq`

## Requirements
- R1: Register map, word addressed. Address 0 bit 0 is the sleep arm bit. Address 1 bit 0 is the warm-boot flag. Address 2 holds the wake-to-enable delay D. Address 3 holds the ramp timeout V. Address 4 holds the reset hold count H. Addresses 2 to 4 read back what was last written, and unused bits read 0.
- R2: While the block is idle and armed, a wake-up pulse is accepted on the next rising clock edge. Acceptance clears the arm bit in hardware, and core_rst_o rises at that same edge.
- R3: A wake-up while the arm bit is 0 is ignored: pwr_en_o and core_rst_o stay 0 and the arm bit stays 0. This holds both from idle and after the arm bit was set and then cleared again.
- R4: pwr_en_o rises D+1 clock cycles after the acceptance edge. D = 0 gives one cycle.
- R5: pwr_ok_i passes through two synchronizing flops. If pwr_ok_i rises m cycles after pwr_en_o rises, pwr_en_o stays high for m+2 cycles, as long as that is shorter than the timeout and at least EN_MIN.
- R6: If pwr_ok_i stays low, pwr_en_o stays high for V+1 cycles, provided V+1 is at least EN_MIN.
- R7: pwr_en_o stays high for at least EN_MIN cycles (default 3), even when the timeout is 0.
- R8: core_rst_o is 1 whenever pwr_en_o is 1. After pwr_en_o falls, core_rst_o stays 1 for H+1 more cycles.
- R9: After power-on reset, core_rst_o is 1 for RH_INIT+1 cycles, counting the cycle in which reset is released (default 8). The arm bit, the warm flag and pwr_en_o are 0, and a warm flag set before the reset is cleared.
- R10: The warm flag is set when core_rst_o falls after a wake-up. Writing 1 to address 1 bit 0 clears it, and writing 0 leaves it unchanged. When a clear and a set fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i (combinational) |
| wake_i | input | 1 | Wake-up event |
| pwr_ok_i | input | 1 | Power-good from regulator (asynchronous) |
| pwr_en_o | output | 1 | Regulator power-on enable |
| core_rst_o | output | 1 | Core reset, active high |

## Verification
Wake-up sequences are run with power-good arriving early, arriving late and never arriving. Comparing the high time of the enable in these runs shows which of the two end conditions governs, and exposes the two-cycle synchronizer latency. A zero timeout shows the minimum-width floor at work, and zero delay and zero hold values check the off-by-one rule for counts. Wake-ups with the arm bit clear, and after an arm-then-disarm, check that unarmed events are ignored. A status clear written in the very cycle the flag is set, and a power-on reset issued while the flag is set, check the flag's priority and its cold-boot clearing.

// File: rtl/dslp_pkg.sv
package dslp_pkg;

   typedef enum logic [2:0] {
      ST_ACTIVE = 3'd0,
      ST_SLEEP  = 3'd1,
      ST_PD     = 3'd2,
      ST_UP     = 3'd3,
      ST_HOLD   = 3'd4
   } dslp_state_e;

   localparam logic [2:0] A_CTRL = 3'd0;
   localparam logic [2:0] A_STAT = 3'd1;
   localparam logic [2:0] A_PD   = 3'd2;
   localparam logic [2:0] A_VR   = 3'd3;
   localparam logic [2:0] A_RH   = 3'd4;

   localparam int NUM_CNT = 3;

endpackage

// File: rtl/dslp_sync.sv
module dslp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   initial begin : stage_chk
      assert (STAGES >= 2) else $fatal(1, "dslp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain[g] <= 1'b0;
               else         chain[g] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain[g] <= 1'b0;
               else         chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/dslp_timer.sv
module dslp_timer #(
   parameter int          W    = 16,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         done_o
);

   logic [W-1:0] cnt_q;

   assign done_o = (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= INIT;
      else if (load_i)  cnt_q <= val_i;
      else if (!done_o) cnt_q <= cnt_q - 1'b1;
   end

endmodule

// File: rtl/dslp_regs.sv
module dslp_regs
   import dslp_pkg::*;
#(
   parameter int          W       = 16,
   parameter int          AW      = 3,
   parameter logic [W-1:0] PD_INIT = 16'd4,
   parameter logic [W-1:0] VR_INIT = 16'd15,
   parameter logic [W-1:0] RH_INIT = 16'd7
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [W-1:0]  wdata_i,
   output logic [W-1:0]  rdata_o,
   input  logic          arm_clr_i,
   input  logic          warm_set_i,
   output logic          arm_o,
   output logic          warm_o,
   output logic [W-1:0]  pd_o,
   output logic [W-1:0]  vr_o,
   output logic [W-1:0]  rh_o
);

   initial begin : width_chk
      assert (AW >= 3) else $fatal(1, "dslp_regs: AW must be at least 3");
   end

   logic         arm_q;
   logic         warm_q;
   logic [W-1:0] cnt_q [NUM_CNT];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  arm_q <= 1'b0;
      else if (arm_clr_i)                           arm_q <= 1'b0;
      else if (we_i && addr_i == AW'(A_CTRL))       arm_q <= wdata_i[0];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) warm_q <= 1'b0;
      else         warm_q <= warm_set_i |
                             (warm_q & ~(we_i && addr_i == AW'(A_STAT) && wdata_i[0]));
   end

   genvar g;
   generate
      for (g = 0; g < NUM_CNT; g++) begin : g_cnt
         localparam logic [W-1:0] RV = (g == 0) ? PD_INIT : (g == 1) ? VR_INIT : RH_INIT;
         localparam logic [AW-1:0] MY_ADDR = AW'(A_PD) + AW'(g);
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                      cnt_q[g] <= RV;
            else if (we_i && addr_i == MY_ADDR) cnt_q[g] <= wdata_i;
         end
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         AW'(A_CTRL): rdata_o = {{(W-1){1'b0}}, arm_q};
         AW'(A_STAT): rdata_o = {{(W-1){1'b0}}, warm_q};
         AW'(A_PD):   rdata_o = cnt_q[0];
         AW'(A_VR):   rdata_o = cnt_q[1];
         AW'(A_RH):   rdata_o = cnt_q[2];
         default:     rdata_o = '0;
      endcase
   end

   assign arm_o  = arm_q;
   assign warm_o = warm_q;
   assign pd_o   = cnt_q[0];
   assign vr_o   = cnt_q[1];
   assign rh_o   = cnt_q[2];

endmodule

// File: rtl/dslp_fsm.sv
module dslp_fsm
   import dslp_pkg::*;
#(
   parameter int W      = 16,
   parameter int EN_MIN = 3
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         arm_i,
   input  logic         wake_i,
   input  logic         ok_i,
   input  logic         tdone_i,
   input  logic [W-1:0] pd_i,
   input  logic [W-1:0] vr_i,
   input  logic [W-1:0] rh_i,
   output logic         load_o,
   output logic [W-1:0] load_val_o,
   output logic         arm_clr_o,
   output logic         warm_set_o,
   output logic         pwr_en_o,
   output logic         core_rst_o,
   output dslp_state_e  state_o,
   output logic         wake_hold_o
);

   localparam int DW = $clog2(EN_MIN + 1);

   initial begin : min_chk
      assert (EN_MIN >= 1) else $fatal(1, "dslp_fsm: EN_MIN must be at least 1");
   end

   dslp_state_e   state_q, state_d;
   logic [DW-1:0] dwell_q;
   logic          dwell_ok;
   logic          wake_hold_q;
   logic          pwr_en_q, core_rst_q;

   assign dwell_ok = (dwell_q >= DW'(EN_MIN - 1));

   always_comb begin
      state_d    = state_q;
      load_o     = 1'b0;
      load_val_o = '0;
      arm_clr_o  = 1'b0;
      warm_set_o = 1'b0;
      case (state_q)
         ST_ACTIVE: if (arm_i) state_d = ST_SLEEP;
         ST_SLEEP: begin
            if (!arm_i) begin
               state_d = ST_ACTIVE;
            end else if (wake_i) begin
               state_d    = ST_PD;
               load_o     = 1'b1;
               load_val_o = pd_i;
               arm_clr_o  = 1'b1;
            end
         end
         ST_PD: begin
            if (tdone_i) begin
               state_d    = ST_UP;
               load_o     = 1'b1;
               load_val_o = vr_i;
            end
         end
         ST_UP: begin
            if ((ok_i || tdone_i) && dwell_ok) begin
               state_d    = ST_HOLD;
               load_o     = 1'b1;
               load_val_o = rh_i;
            end
         end
         ST_HOLD: begin
            if (tdone_i) begin
               state_d    = ST_ACTIVE;
               warm_set_o = wake_hold_q;
            end
         end
         default: state_d = ST_ACTIVE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= ST_HOLD;
         dwell_q     <= '0;
         wake_hold_q <= 1'b0;
         pwr_en_q    <= 1'b0;
         core_rst_q  <= 1'b1;
      end else begin
         state_q <= state_d;
         if (state_q != ST_UP)  dwell_q <= '0;
         else if (!dwell_ok)    dwell_q <= dwell_q + 1'b1;
         if (arm_clr_o)         wake_hold_q <= 1'b1;
         else if (state_q == ST_HOLD && tdone_i) wake_hold_q <= 1'b0;
         pwr_en_q   <= (state_d == ST_UP);
         core_rst_q <= (state_d == ST_PD) || (state_d == ST_UP) || (state_d == ST_HOLD);
      end
   end

   assign pwr_en_o    = pwr_en_q;
   assign core_rst_o  = core_rst_q;
   assign state_o     = state_q;
   assign wake_hold_o = wake_hold_q;

endmodule

// File: rtl/dslp_seq.sv
module dslp_seq
   import dslp_pkg::*;
#(
   parameter int          W           = 16,
   parameter int          AW          = 3,
   parameter int          SYNC_STAGES = 2,
   parameter int          EN_MIN      = 3,
   parameter logic [W-1:0] PD_INIT     = 16'd4,
   parameter logic [W-1:0] VR_INIT     = 16'd15,
   parameter logic [W-1:0] RH_INIT     = 16'd7
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          reg_we_i,
   input  logic [AW-1:0] reg_addr_i,
   input  logic [W-1:0]  reg_wdata_i,
   output logic [W-1:0]  reg_rdata_o,
   input  logic          wake_i,
   input  logic          pwr_ok_i,
   output logic          pwr_en_o,
   output logic          core_rst_o
);

   logic         arm, arm_clr, warm, warm_set;
   logic [W-1:0] pd_val, vr_val, rh_val;
   logic         ok_s;
   logic         tmr_load, tmr_done;
   logic [W-1:0] tmr_val;
   dslp_state_e  state;
   logic         wake_hold;

   dslp_regs #(
      .W(W), .AW(AW), .PD_INIT(PD_INIT), .VR_INIT(VR_INIT), .RH_INIT(RH_INIT)
   ) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
      .arm_clr_i(arm_clr), .warm_set_i(warm_set),
      .arm_o(arm), .warm_o(warm),
      .pd_o(pd_val), .vr_o(vr_val), .rh_o(rh_val)
   );

   dslp_sync #(.STAGES(SYNC_STAGES)) u_ok_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pwr_ok_i), .q_o(ok_s)
   );

   dslp_timer #(.W(W), .INIT(RH_INIT)) u_timer (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .load_i(tmr_load), .val_i(tmr_val), .done_o(tmr_done)
   );

   dslp_fsm #(.W(W), .EN_MIN(EN_MIN)) u_fsm (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .arm_i(arm), .wake_i(wake_i), .ok_i(ok_s), .tdone_i(tmr_done),
      .pd_i(pd_val), .vr_i(vr_val), .rh_i(rh_val),
      .load_o(tmr_load), .load_val_o(tmr_val),
      .arm_clr_o(arm_clr), .warm_set_o(warm_set),
      .pwr_en_o(pwr_en_o), .core_rst_o(core_rst_o),
      .state_o(state), .wake_hold_o(wake_hold)
   );

endmodule

// File: rtl/dslp_seq_chk.sv
module dslp_seq_chk
   import dslp_pkg::*;
#(
   parameter int EN_MIN = 3
) (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        wake_i,
   input logic        pwr_en_o,
   input logic        core_rst_o,
   input logic        arm,
   input logic        warm,
   input logic        ok_s,
   input logic        tmr_done,
   input logic        wake_hold,
   input dslp_state_e state
);

   logic [15:0] hi_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                hi_cnt <= '0;
      else if (!pwr_en_o)         hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
   end

   assert_wake_clears_arm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == ST_SLEEP && arm && wake_i) |=> !arm);

   assert_idle_no_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == ST_ACTIVE) |=> !pwr_en_o);

   assert_enable_after_delay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pwr_en_o) |-> ($past(state) == ST_PD && $past(tmr_done)));

   assert_enable_drop_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pwr_en_o) |-> $past(ok_s || tmr_done));

   assert_enable_min_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pwr_en_o) |-> (hi_cnt >= 16'(EN_MIN)));

   assert_enable_in_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwr_en_o |-> core_rst_o);

   assert_warm_on_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(core_rst_o) && $past(wake_hold)) |-> warm);

endmodule

bind dslp_seq dslp_seq_chk #(.EN_MIN(EN_MIN)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .wake_i(wake_i),
   .pwr_en_o(pwr_en_o), .core_rst_o(core_rst_o),
   .arm(arm), .warm(warm), .ok_s(ok_s), .tmr_done(tmr_done),
   .wake_hold(wake_hold), .state(state)
);

// File: tb/dslp_seq_test.sv
module dslp_seq_test;

   localparam int EN_MIN  = 3;
   localparam int RH_INIT = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        wake = 1'b0;
   logic        pwr_ok = 1'b0;
   logic        pwr_en;
   logic        core_rst;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   dslp_seq uut (
      .clk_i(clk), .rst_ni(rst_n),
      .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .wake_i(wake), .pwr_ok_i(pwr_ok),
      .pwr_en_o(pwr_en), .core_rst_o(core_rst)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      addr = a;
      #1 v = int'(rdata);
   endtask

   task automatic t_por(input string tag);
      int n;
      int v;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk({tag, " enable low in reset"}, int'(pwr_en), 0);
      rst_n = 1'b1;
      n = 0;
      while (core_rst && n < 1000) begin
         n++;
         @(negedge clk);
      end
      chk({tag, " core reset hold cycles"}, n, RH_INIT + 1);
      rd(3'd0, v); chk({tag, " arm bit"}, v, 0);
      rd(3'd1, v); chk({tag, " warm flag"}, v, 0);
      chk({tag, " enable low"}, int'(pwr_en), 0);
   endtask

   task automatic t_regs();
      int v;
      wr(3'd2, 16'd9);    rd(3'd2, v); chk("R1 delay readback", v, 9);
      wr(3'd3, 16'hA5C3); rd(3'd3, v); chk("R1 ramp readback", v, 16'hA5C3);
      wr(3'd4, 16'h0102); rd(3'd4, v); chk("R1 hold readback", v, 16'h0102);
      wr(3'd0, 16'hFFFE); rd(3'd0, v); chk("R1 arm bit zero write", v, 0);
   endtask

   task automatic t_ignore();
      int seen;
      int v;
      seen = 0;
      @(negedge clk);
      wake = 1'b1;
      repeat (10) begin
         @(negedge clk);
         if (pwr_en || core_rst) seen++;
      end
      wake = 1'b0;
      chk("R3 wake unarmed ignored", seen, 0);
      rd(3'd0, v); chk("R3 arm stays clear", v, 0);
      wr(3'd0, 16'd1);
      @(negedge clk);
      wr(3'd0, 16'd0);
      @(negedge clk);
      @(negedge clk);
      wake = 1'b1;
      repeat (8) begin
         @(negedge clk);
         if (pwr_en || core_rst) seen++;
      end
      wake = 1'b0;
      chk("R3 wake after disarm ignored", seen, 0);
   endtask

   task automatic t_wake(input string tag, input int pd, input int vr, input int rh,
                         input int m, input bit clr_at_exit, input bit do_clear);
      int n, h, r, v, exp_h;
      wr(3'd2, 16'(pd));
      wr(3'd3, 16'(vr));
      wr(3'd4, 16'(rh));
      wr(3'd0, 16'd1);
      @(negedge clk);
      @(negedge clk);
      rd(3'd0, v); chk("R1 arm set", v, 1);
      wake = 1'b1;
      @(negedge clk);
      wake = 1'b0;
      chk("R2 core reset on accept", int'(core_rst), 1);
      rd(3'd0, v); chk("R2 arm cleared by wake", v, 0);
      n = 1;
      while (!pwr_en && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk("R4 wake to enable delay", n, pd + 2);
      exp_h = vr + 1;
      if (m > 0 && m + 2 < exp_h) exp_h = m + 2;
      if (exp_h < EN_MIN) exp_h = EN_MIN;
      h = 1;
      if (m == 1) pwr_ok = 1'b1;
      while (h < 5000) begin
         @(negedge clk);
         if (!pwr_en) break;
         h++;
         if (h == m) pwr_ok = 1'b1;
      end
      chk({tag, " enable high cycles"}, h, exp_h);
      r = 0;
      while (core_rst && r < 5000) begin
         r++;
         if (clr_at_exit && r == rh + 1) begin
            we = 1'b1; addr = 3'd1; wdata = 16'd1;
         end
         @(negedge clk);
         we = 1'b0;
      end
      chk("R8 reset hold after enable", r, rh + 1);
      pwr_ok = 1'b0;
      rd(3'd1, v); chk({"R10 warm flag set", clr_at_exit ? " over clear" : ""}, v, 1);
      if (do_clear) begin
         wr(3'd1, 16'd0); rd(3'd1, v); chk("R10 write zero keeps flag", v, 1);
         wr(3'd1, 16'd1); rd(3'd1, v); chk("R10 write one clears flag", v, 0);
      end
   endtask

   initial begin
      t_por("R9");
      t_regs();
      t_ignore();
      t_wake("R5", 2, 20, 3, 4, 1'b0, 1'b1);
      t_wake("R6", 0, 7, 0, 0, 1'b0, 1'b1);
      t_wake("R7", 5, 0, 2, 0, 1'b1, 1'b1);
      t_wake("R5 late", 1, 30, 4, 2, 1'b0, 1'b0);
      t_por("R9 after warm");
      summary();
      $finish;
   end

   initial begin
      #1000000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      summary();
      $finish;
   end

endmodule